// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block keeps the single reservation that lets one hardware thread run an atomic read-modify-write as a linked load followed by a conditional store. A request port presents one operation per cycle: a linked load, a conditional store, an ordinary store from the same thread, or an exception return. Each request carries a physical byte address. A second port reports stores made by other agents.

A linked load arms the reservation on one aligned 32-bit word. Anything that could break atomicity disarms it. This covers a conditional store (pass or fail), an exception return, an ordinary store to the reserved word, and an external store that hits the reserved word. Each conditional store gets a one-cycle verdict in the cycle after its request. The current link state and the word address are always visible on the outputs.

Top module: `llres_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `link_valid`=0, `link_addr`=0, `sc_done`=0 and `sc_ok`=0.
- R2: A request with `req_op`=2'b00 (linked load) sets `link_valid` in the next cycle. `link_addr` then holds the request address with its two low bits forced to zero.
- R3: A request with `req_op`=2'b01 (conditional store) made while `link_valid` is 1, with no matching snoop in that cycle, gives `sc_done`=1 and `sc_ok`=1 in the next cycle.
- R4: A conditional store made while `link_valid` is 0 gives `sc_done`=1 and `sc_ok`=0 in the next cycle.
- R5: A conditional store clears `link_valid` in the next cycle, whether it passed or failed.
- R6: A request with `req_op`=2'b11 (exception return) clears `link_valid` in the next cycle.
- R7: A request with `req_op`=2'b10 (ordinary store) clears `link_valid` in the next cycle when the address matches the reserved word, ignoring address bits [1:0]. A store to any other word leaves `link_valid` and `link_addr` unchanged.
- R8: A `snoop_valid` cycle whose address matches the reserved word, ignoring bits [1:0], clears `link_valid` in the next cycle. A non-matching snoop changes neither output.
- R9: When a matching snoop and a conditional store arrive in the same cycle, the store fails (`sc_ok`=0).
- R10: When a linked load and a matching snoop arrive in the same cycle, the linked load wins: the reservation is armed on the new address.
- R11: `sc_done` and `sc_ok` are high only in the cycle right after a conditional-store request. `sc_ok` is never high without `sc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 linked load, 01 conditional store, 10 ordinary store, 11 exception return |
| req_addr | input | ADDR_W | Physical byte address of the request |
| snoop_valid | input | 1 | External store observed |
| snoop_addr | input | ADDR_W | Byte address of the external store |
| sc_done | output | 1 | Conditional-store verdict present |
| sc_ok | output | 1 | Conditional store succeeded |
| link_valid | output | 1 | Reservation armed |
| link_addr | output | ADDR_W | Reserved word address, low bits zero |

## Verification
The hardest case to reach is an external store landing in exactly the same cycle as a conditional store or a linked load, with an address that matches the reserved word only after the low two bits are dropped. Directed sequences build these collisions on purpose. The snoop address uses the reserved word with different byte bits in those cases.

A random phase then draws addresses from a pool of four words, with random byte offsets. It fires snoops on about a third of cycles, so matches and collisions also occur often without being forced.

// File: rtl/llres_pkg.sv
package llres_pkg;
  typedef enum logic [1:0] {
    OP_LINK_LOAD   = 2'b00,
    OP_COND_STORE  = 2'b01,
    OP_PLAIN_STORE = 2'b10,
    OP_EXC_RETURN  = 2'b11
  } llres_op_e;
endpackage

// File: rtl/llres_word_match.sv
module llres_word_match #(
  parameter int ADDR_W = 32,
  parameter int GRAN_LSB = 2
) (
  input  logic                   en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [ADDR_W-GRAN_LSB-1:0] tag_i,
  output logic                   hit_o
);
  localparam int TAG_W = ADDR_W - GRAN_LSB;

  logic unused_byte_bits;
  assign unused_byte_bits = ^addr_i[GRAN_LSB-1:0];

  logic [TAG_W-1:0] addr_tag;
  assign addr_tag = addr_i[ADDR_W-1:GRAN_LSB];

  always_comb begin
    hit_o = en_i && (addr_tag == tag_i);
  end
endmodule

// File: rtl/llres_link_reg.sv
module llres_link_reg #(
  parameter int TAG_W = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             clr_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      tag_o   <= set_tag_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/llres_result.sv
module llres_result (
  input  logic clk,
  input  logic rst,
  input  logic sc_req_i,
  input  logic sc_pass_i,
  output logic sc_done_o,
  output logic sc_ok_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sc_done_o <= 1'b0;
      sc_ok_o   <= 1'b0;
    end else begin
      sc_done_o <= sc_req_i;
      sc_ok_o   <= sc_req_i && sc_pass_i;
    end
  end
endmodule

// File: rtl/llres_monitor.sv
module llres_monitor
  import llres_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GRAN_LSB = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              sc_done,
  output logic              sc_ok,
  output logic              link_valid,
  output logic [ADDR_W-1:0] link_addr
);
  localparam int TAG_W = ADDR_W - GRAN_LSB;

  llres_op_e op;
  assign op = llres_op_e'(req_op);

  logic ll_req, sc_req, st_req, er_req;
  always_comb begin
    ll_req = req_valid && (op == OP_LINK_LOAD);
    sc_req = req_valid && (op == OP_COND_STORE);
    st_req = req_valid && (op == OP_PLAIN_STORE);
    er_req = req_valid && (op == OP_EXC_RETURN);
  end

  logic             armed;
  logic [TAG_W-1:0] tag_q;
  logic             own_hit, snoop_hit;

  llres_word_match #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_own_cmp (
    .en_i   (armed && st_req),
    .addr_i (req_addr),
    .tag_i  (tag_q),
    .hit_o  (own_hit)
  );

  llres_word_match #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_snoop_cmp (
    .en_i   (armed && snoop_valid),
    .addr_i (snoop_addr),
    .tag_i  (tag_q),
    .hit_o  (snoop_hit)
  );

  logic clr_any, sc_pass;
  always_comb begin
    clr_any = sc_req || er_req || own_hit || snoop_hit;
    sc_pass = armed && !snoop_hit;
  end

  llres_link_reg #(.TAG_W(TAG_W)) u_link (
    .clk       (clk),
    .rst       (rst),
    .set_i     (ll_req),
    .set_tag_i (req_addr[ADDR_W-1:GRAN_LSB]),
    .clr_i     (clr_any),
    .valid_o   (armed),
    .tag_o     (tag_q)
  );

  llres_result u_result (
    .clk       (clk),
    .rst       (rst),
    .sc_req_i  (sc_req),
    .sc_pass_i (sc_pass),
    .sc_done_o (sc_done),
    .sc_ok_o   (sc_ok)
  );

  assign link_valid = armed;
  assign link_addr  = {tag_q, {GRAN_LSB{1'b0}}};
endmodule

// File: rtl/llres_monitor_checker.sv
module llres_monitor_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              sc_done,
  input logic              sc_ok,
  input logic              link_valid,
  input logic [ADDR_W-1:0] link_addr
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!link_valid && link_addr == '0 && !sc_done && !sc_ok));

  a_r2_ll_arms: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'b00) |=> (link_valid && link_addr[1:0] == 2'b00));

  a_r4_fail_unarmed: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'b01 && !link_valid) |=> (sc_done && !sc_ok));

  a_r5_sc_disarms: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'b01) |=> !link_valid);

  a_r6_eret_disarms: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'b11) |=> !link_valid);

  a_r11_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_op == 2'b01) |=> !sc_done);

  a_r11_ok_needs_done: assert property (@(posedge clk) disable iff (rst)
    sc_ok |-> sc_done);
endmodule

bind llres_monitor llres_monitor_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .sc_done    (sc_done),
  .sc_ok      (sc_ok),
  .link_valid (link_valid),
  .link_addr  (link_addr)
);

// File: tb/llres_monitor_tb.sv
module llres_monitor_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic          snoop_valid;
  logic [AW-1:0] snoop_addr;
  logic          sc_done, sc_ok, link_valid;
  logic [AW-1:0] link_addr;

  always #4 clk = ~clk;

  llres_monitor u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .sc_done(sc_done), .sc_ok(sc_ok), .link_valid(link_valid), .link_addr(link_addr)
  );

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  // reference model state
  bit          m_valid;
  logic [AW-1:0] m_addr;
  bit          e_done, e_ok;

  function automatic logic [AW-1:0] word_of(logic [AW-1:0] a);
    return {a[AW-1:2], 2'b00};
  endfunction

  function automatic void model(bit v, logic [1:0] op, logic [AW-1:0] a,
                                bit sv, logic [AW-1:0] sa);
    bit snoop_hit;
    bit own_hit;
    snoop_hit = sv && m_valid && (word_of(sa) == m_addr);
    own_hit   = v && op == 2'b10 && m_valid && (word_of(a) == m_addr);
    e_done = v && op == 2'b01;
    e_ok   = e_done && m_valid && !snoop_hit;
    if (v && op == 2'b00) begin
      m_valid = 1;
      m_addr  = word_of(a);
    end else if ((v && (op == 2'b01 || op == 2'b11)) || own_hit || snoop_hit) begin
      m_valid = 0;
    end
  endfunction

  task automatic check(string tag);
    vectors++;
    if (sc_done !== e_done) begin
      errors++; $display("FAIL %s sc_done act=%0b exp=%0b", tag, sc_done, e_done);
    end
    if (sc_ok !== e_ok) begin
      errors++; $display("FAIL %s sc_ok act=%0b exp=%0b", tag, sc_ok, e_ok);
    end
    if (link_valid !== m_valid) begin
      errors++; $display("FAIL %s link_valid act=%0b exp=%0b", tag, link_valid, m_valid);
    end
    if (m_valid && link_addr !== m_addr) begin
      errors++; $display("FAIL %s link_addr act=%h exp=%h", tag, link_addr, m_addr);
    end
  endtask

  task automatic step(bit v, logic [1:0] op, logic [AW-1:0] a,
                      bit sv, logic [AW-1:0] sa, string tag);
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = a;
    snoop_valid = sv; snoop_addr = sa;
    model(v, op, a, sv, sa);
    @(posedge clk);
    #2;
    check(tag);
  endtask

  initial begin
    rst = 1; req_valid = 0; req_op = 0; req_addr = 0; snoop_valid = 0; snoop_addr = 0;
    m_valid = 0; m_addr = 0; e_done = 0; e_ok = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    vectors++;
    if (link_valid !== 0 || link_addr !== 0 || sc_done !== 0 || sc_ok !== 0) begin
      errors++;
      $display("FAIL R1 reset act=%0b/%h/%0b/%0b exp=0/0/0/0", link_valid, link_addr, sc_done, sc_ok);
    end
    @(negedge clk); rst = 0;

    step(1, 2'b00, 32'h0000_1003, 0, 0, "R2");            // arm, low bits dropped
    step(0, 2'b00, 0, 0, 0, "R11");                        // idle, no verdict
    step(1, 2'b01, 32'h0000_1000, 0, 0, "R3");            // pass
    step(1, 2'b01, 32'h0000_1000, 0, 0, "R4");            // fail, unarmed
    step(1, 2'b00, 32'h0000_2000, 0, 0, "R2");
    step(1, 2'b11, 0, 0, 0, "R6");                         // exception return
    step(1, 2'b01, 32'h0000_2000, 0, 0, "R5");            // fails
    step(1, 2'b00, 32'h0000_3000, 0, 0, "R2");
    step(1, 2'b10, 32'h0000_3004, 0, 0, "R7");            // other word: keep
    step(1, 2'b10, 32'h0000_3002, 0, 0, "R7");            // same word: clear
    step(1, 2'b00, 32'h0000_4000, 0, 0, "R2");
    step(0, 2'b00, 0, 1, 32'h0000_4008, "R8");            // non-matching snoop
    step(0, 2'b00, 0, 1, 32'h0000_4001, "R8");            // matching snoop
    step(1, 2'b00, 32'h0000_5000, 0, 0, "R2");
    step(1, 2'b01, 32'h0000_5000, 1, 32'h0000_5003, "R9"); // collision fails
    step(1, 2'b00, 32'h0000_6000, 0, 0, "R2");
    step(1, 2'b00, 32'h0000_7000, 1, 32'h0000_6000, "R10"); // LL wins
    step(1, 2'b00, 32'h0000_7000, 1, 32'h0000_7002, "R10"); // LL wins on own word
    step(1, 2'b01, 32'h0000_7000, 0, 0, "R10");            // reservation live -> pass

    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a, s;
      logic [1:0] op;
      bit v, sv;
      string tag;
      a  = {26'h0, 2'($urandom_range(3)), 4'h0} | 32'($urandom_range(3));
      s  = {26'h0, 2'($urandom_range(3)), 4'h0} | 32'($urandom_range(3));
      op = 2'($urandom_range(3));
      v  = ($urandom_range(9) < 8);
      sv = ($urandom_range(2) == 0);
      case (op)
        2'b00: tag = "R2";
        2'b01: tag = "R5";
        2'b10: tag = "R7";
        default: tag = "R6";
      endcase
      if (!v) tag = "R8";
      step(v, op, a, sv, s, tag);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
  end
endmodule